// File: doc/BRIEF.md
# Embedded-Clock Serial Symbol Framer

This block turns a stream of 16-bit parallel words, each paired with two low-rate side-channel bits, into a continuous one-bit serial line. Each word becomes a 28-bit symbol that is sent most significant bit first, one bit per clock. Every symbol opens with a forced one and closes with a forced zero. As a result, the line has a one-to-zero edge inside every symbol and a zero-to-one edge at every symbol boundary. The data field is whitened with a fixed keystream, and a 4-bit check code protects the data and side bits together. The side bits ride in every symbol, so their delivery never waits for a gap in the data stream.

The receive half of the same block watches an incoming serial line and finds symbol boundaries from the fixed bits alone. It checks them over several symbols before it reports lock. It then removes the whitening, delivers each word with its side bits, and flags any symbol whose check code does not match. One clock runs the whole block, at the bit rate. The transmit side asks for a new word once every 28 clocks through a take strobe.

Top module: `symbol_link_framer`

## Requirements
- R1: A symbol is 28 bits sent MSB first, one bit per clock. Its bit 27 is the first bit on the line and its bit 0 is the last. `tx_take` is high for exactly one clock in every 28, and this includes the first clock after reset. `word_valid`, `word_in` and `ctl_in` are sampled at the end of that clock, and the first bit of the new symbol appears on `serial_out` in the next clock. Bits 10:9 carry `ctl_in[1:0]`.
- R2: Bit 27 of every symbol is 1 and bit 0 is 0.
- R3: Bits 26:11 hold `word_in` XOR a 16-bit keystream. The keystream comes from a 7-bit register seeded with 7'h7F at the start of every symbol. Each key bit is s[6]^s[5], and the register then shifts left taking that key bit as its new s[0]. The first key bit goes with `word_in[15]` (polynomial x^7+x^6+1).
- R4: Bits 8:5 hold the CRC of the 18-bit message {word_in, ctl_in}, MSB first. The CRC uses polynomial x^4+x+1 with an initial value of zero and is taken over the unwhitened data.
- R5: Bits 4:1 hold the bitwise inverse of the CRC nibble.
- R6: A symbol sampled while `word_valid` is low carries all-zero data and all-zero side bits.
- R7: An incoming 28-bit window is in pattern when bit 27 is 1, bit 0 is 0 and bits 4:1 equal the inverse of bits 8:5. `rx_lock` rises only after 4 consecutive in-pattern windows spaced exactly 28 clocks apart.
- R8: While locked, one out-of-pattern window keeps the lock and produces no output word. Two consecutive out-of-pattern windows drop `rx_lock`, and the search for alignment restarts.
- R9: While locked, every in-pattern window gives a one-clock `rx_valid` pulse with the unwhitened word and the side bits. Words arrive in the order they were sent, with none repeated or reordered.
- R10: `rx_crc_err` pulses together with `rx_valid` when the received CRC differs from the one recomputed over the received word and side bits. A single flipped data bit on the line triggers it.
- R11: While `rst` is high, `serial_out`, `rx_lock`, `rx_valid` and `rx_crc_err` are 0, `tx_take` is 1, and `rx_word` and `rx_ctl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Word present; when low an idle symbol is sent |
| word_in | input | 16 | Parallel data word |
| ctl_in | input | 2 | Side-channel bits for the same symbol |
| tx_take | output | 1 | Inputs are sampled at the end of this clock |
| serial_out | output | 1 | Serial line out |
| serial_in | input | 1 | Serial line in |
| rx_word | output | 16 | Recovered data word |
| rx_ctl | output | 2 | Recovered side-channel bits |
| rx_valid | output | 1 | One-clock pulse per delivered word |
| rx_lock | output | 1 | Symbol alignment held |
| rx_crc_err | output | 1 | Check-code mismatch on the delivered word |

## Verification
The first bit of a symbol is due on `serial_out` one clock after the `tx_take` clock, and each later bit follows one clock after the one before it. The bench therefore queues the 28 expected bits at the moment it sees `tx_take` and pops one bit each clock. A received word shows up one clock after its last bit has entered the receive window. `rx_lock` changes one clock after the deciding window. Because the loopback delay is arbitrary, the bench does not fix the arrival cycle of received words. It matches each `rx_valid` pulse against its ordered record of sent symbols and samples all outputs on the falling edge.

// File: rtl/sym_framer_pkg.sv
package sym_framer_pkg;

    localparam int SYM_W  = 28;
    localparam int PAY_W  = 16;
    localparam int CTL_W  = 2;
    localparam int CRC_W  = 4;
    localparam int LFSR_W = 7;
    localparam int MSG_W  = PAY_W + CTL_W;
    localparam int IDX_W  = $clog2(SYM_W);

    typedef struct packed {
        logic             clk1;
        logic [PAY_W-1:0] pay;
        logic [CTL_W-1:0] ctl;
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] bal;
        logic             clk0;
    } symbol_t;

    typedef struct packed {
        logic [PAY_W-1:0] data;
        logic [CTL_W-1:0] ctl;
    } word_t;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;

    // Keystream for one symbol; first key bit lands on the data MSB.
    function automatic logic [PAY_W-1:0] scr_mask(input logic [LFSR_W-1:0] seed);
        logic [LFSR_W-1:0] s;
        logic              k;
        logic [PAY_W-1:0]  m;
        s = seed;
        m = '0;
        for (int i = PAY_W - 1; i >= 0; i--) begin
            k    = s[6] ^ s[5];
            m[i] = k;
            s    = {s[LFSR_W-2:0], k};
        end
        return m;
    endfunction

    // x^4+x+1, zero start, message taken MSB first.
    function automatic logic [CRC_W-1:0] crc4(input logic [MSG_W-1:0] msg);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb   = c[CRC_W-1] ^ msg[i];
            c    = {c[CRC_W-2:0], fb};
            c[1] = c[1] ^ fb;
        end
        return c;
    endfunction

    function automatic symbol_t build_symbol(input word_t w, input logic [PAY_W-1:0] mask);
        symbol_t s;
        s.clk1 = 1'b1;
        s.pay  = w.data ^ mask;
        s.ctl  = w.ctl;
        s.crc  = crc4(w);
        s.bal  = ~s.crc;
        s.clk0 = 1'b0;
        return s;
    endfunction

    function automatic logic align_ok(input symbol_t s);
        return s.clk1 && !s.clk0 && (s.bal == ~s.crc);
    endfunction

endpackage

// File: rtl/sym_tx.sv
module sym_tx
    import sym_framer_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 7'h7F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_valid,
    input  logic [PAY_W-1:0] word_in,
    input  logic [CTL_W-1:0] ctl_in,
    output logic             tx_take,
    output logic             serial_out
);
    localparam logic [PAY_W-1:0] MASK     = scr_mask(SEED);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYM_W - 1);

    logic [IDX_W-1:0] bit_idx;
    logic [SYM_W-1:0] shreg;
    word_t            next_word;

    always_comb begin
        next_word.data = word_valid ? word_in : '0;
        next_word.ctl  = word_valid ? ctl_in  : '0;
    end

    assign tx_take    = (bit_idx == LAST_IDX);
    assign serial_out = shreg[SYM_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx <= LAST_IDX;
            shreg   <= '0;
        end else if (tx_take) begin
            bit_idx <= '0;
            shreg   <= build_symbol(next_word, MASK);
        end else begin
            bit_idx <= bit_idx + 1'b1;
            shreg   <= {shreg[SYM_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sym_rx_window.sv
module sym_rx_window
    import sym_framer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    serial_in,
    output symbol_t window,
    output logic    pattern_ok
);
    logic [SYM_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYM_W-2:0], serial_in};
    end

    assign window     = symbol_t'(sh);
    assign pattern_ok = align_ok(window);
endmodule

// File: rtl/sym_lock.sv
module sym_lock
    import sym_framer_pkg::*;
#(
    parameter int LOCK_GOOD = 4,
    parameter int LOSS_MISS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pattern_ok,
    output logic boundary,
    output logic locked,
    output logic emit
);
    localparam int GOOD_W = $clog2(LOCK_GOOD + 1);
    localparam int MISS_W = $clog2(LOSS_MISS + 1);
    localparam logic [IDX_W-1:0]  LAST_PH   = IDX_W'(SYM_W - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_GOOD - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_MISS - 1);

    lock_state_t       state;
    logic [IDX_W-1:0]  phase;
    logic [GOOD_W-1:0] good_cnt;
    logic [MISS_W-1:0] miss_cnt;

    assign boundary = (state != ST_HUNT) && (phase == LAST_PH);
    assign locked   = (state == ST_LOCKED);
    assign emit     = boundary && locked && pattern_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            phase    <= '0;
            good_cnt <= '0;
            miss_cnt <= '0;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (pattern_ok) begin
                        state    <= ST_VERIFY;
                        phase    <= '0;
                        good_cnt <= GOOD_W'(1);
                    end
                end
                ST_VERIFY: begin
                    phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
                    if (boundary) begin
                        if (!pattern_ok) begin
                            state <= ST_HUNT;
                        end else if (good_cnt == GOOD_LAST) begin
                            state    <= ST_LOCKED;
                            miss_cnt <= '0;
                        end else begin
                            good_cnt <= good_cnt + 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
                    if (boundary) begin
                        if (pattern_ok) begin
                            miss_cnt <= '0;
                        end else if (miss_cnt == MISS_LAST) begin
                            state <= ST_HUNT;
                        end else begin
                            miss_cnt <= miss_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/sym_rx_decode.sv
module sym_rx_decode
    import sym_framer_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 7'h7F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             emit,
    input  symbol_t          window,
    output logic [PAY_W-1:0] rx_word,
    output logic [CTL_W-1:0] rx_ctl,
    output logic             rx_valid,
    output logic             rx_crc_err
);
    localparam logic [PAY_W-1:0] MASK = scr_mask(SEED);

    word_t rec;
    logic  mismatch;

    always_comb begin
        rec.data = window.pay ^ MASK;
        rec.ctl  = window.ctl;
        mismatch = (crc4(rec) != window.crc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word    <= '0;
            rx_ctl     <= '0;
            rx_valid   <= 1'b0;
            rx_crc_err <= 1'b0;
        end else begin
            rx_valid   <= emit;
            rx_crc_err <= emit && mismatch;
            if (emit) begin
                rx_word <= rec.data;
                rx_ctl  <= rec.ctl;
            end
        end
    end
endmodule

// File: rtl/symbol_link_framer.sv
module symbol_link_framer
    import sym_framer_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED      = 7'h7F,
    parameter int                LOCK_GOOD = 4,
    parameter int                LOSS_MISS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        word_valid,
    input  logic [15:0] word_in,
    input  logic [1:0]  ctl_in,
    output logic        tx_take,
    output logic        serial_out,
    input  logic        serial_in,
    output logic [15:0] rx_word,
    output logic [1:0]  rx_ctl,
    output logic        rx_valid,
    output logic        rx_lock,
    output logic        rx_crc_err
);
    symbol_t sym_window;
    logic    rx_pat_ok;
    logic    lk_boundary;
    logic    lk_emit;

    sym_tx #(.SEED(SEED)) i_tx (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word_in    (word_in),
        .ctl_in     (ctl_in),
        .tx_take    (tx_take),
        .serial_out (serial_out)
    );

    sym_rx_window i_win (
        .clk        (clk),
        .rst        (rst),
        .serial_in  (serial_in),
        .window     (sym_window),
        .pattern_ok (rx_pat_ok)
    );

    sym_lock #(.LOCK_GOOD(LOCK_GOOD), .LOSS_MISS(LOSS_MISS)) i_lock (
        .clk        (clk),
        .rst        (rst),
        .pattern_ok (rx_pat_ok),
        .boundary   (lk_boundary),
        .locked     (rx_lock),
        .emit       (lk_emit)
    );

    sym_rx_decode #(.SEED(SEED)) i_dec (
        .clk        (clk),
        .rst        (rst),
        .emit       (lk_emit),
        .window     (sym_window),
        .rx_word    (rx_word),
        .rx_ctl     (rx_ctl),
        .rx_valid   (rx_valid),
        .rx_crc_err (rx_crc_err)
    );
endmodule

// File: rtl/sym_framer_checker.sv
module sym_framer_checker (
    input logic clk,
    input logic rst,
    input logic tx_take,
    input logic serial_out,
    input logic rx_valid,
    input logic rx_crc_err,
    input logic rx_lock,
    input logic boundary,
    input logic pattern_ok
);
    logic [5:0] gap;
    logic       seen_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            seen_take <= 1'b0;
        end else begin
            gap       <= tx_take ? 6'd0 : gap + 6'd1;
            seen_take <= seen_take | tx_take;
        end
    end

    AST_TAKE_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (tx_take && seen_take) |-> (gap == 6'd27));                    // R1
    AST_MARK_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> serial_out);                                       // R2
    AST_MARK_LOW_LAST: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> !serial_out);                                      // R2
    AST_LOCK_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_lock) |-> $past(boundary && pattern_ok));             // R7
    AST_LOCK_FALL_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_lock) |-> $past(boundary && !pattern_ok));            // R8
    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_lock);                                         // R9
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        rx_crc_err |-> rx_valid);                                      // R10
endmodule

bind symbol_link_framer sym_framer_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_take    (tx_take),
    .serial_out (serial_out),
    .rx_valid   (rx_valid),
    .rx_crc_err (rx_crc_err),
    .rx_lock    (rx_lock),
    .boundary   (lk_boundary),
    .pattern_ok (rx_pat_ok)
);

// File: tb/test_symbol_link_framer.sv
module test_symbol_link_framer;

    localparam int DLY    = 13;
    localparam int NSYM   = 130;
    localparam int LIMIT  = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        word_valid;
    logic [15:0] word_in;
    logic [1:0]  ctl_in;
    logic        tx_take;
    logic        serial_out;
    logic        serial_in;
    logic [15:0] rx_word;
    logic [1:0]  rx_ctl;
    logic        rx_valid;
    logic        rx_lock;
    logic        rx_crc_err;

    always #5 clk = ~clk;

    symbol_link_framer i_symbol_link_framer (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
        .ctl_in(ctl_in), .tx_take(tx_take), .serial_out(serial_out),
        .serial_in(serial_in), .rx_word(rx_word), .rx_ctl(rx_ctl),
        .rx_valid(rx_valid), .rx_lock(rx_lock), .rx_crc_err(rx_crc_err)
    );

    typedef struct {
        logic [15:0] d;
        logic [1:0]  c;
        bit          bad;
        bit          drop;
        int          seq;
    } rx_ent_t;

    int      n_chk = 0;
    int      n_fail = 0;
    int      bitq[$];
    rx_ent_t rxq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] key16();
        logic [6:0]  s = 7'h7F;
        logic [15:0] m = '0;
        for (int i = 0; i < 16; i++) begin
            m[15-i] = s[6] ^ s[5];
            s = {s[5:0], s[6] ^ s[5]};
        end
        return m;
    endfunction

    function automatic logic [3:0] ref_crc(input logic [17:0] msg);
        logic [21:0] v = {msg, 4'b0000};
        for (int i = 21; i >= 4; i--)
            if (v[i]) v = v ^ (22'b10011 << (i - 4));
        return v[3:0];
    endfunction

    function automatic string region(input int idx, input bit idle);
        if (idle) return "R6";
        if (idx == 27 || idx == 0) return "R2";
        if (idx >= 11) return "R3";
        if (idx >= 9) return "R1";
        if (idx >= 5) return "R4";
        return "R5";
    endfunction

    initial begin
        logic [31:0] dl;
        logic [27:0] sym;
        logic [3:0]  cr;
        logic [15:0] d;
        logic [1:0]  c;
        bit          idle, flip, resync, prev_lock, lock_chk_done, mid_chk_done;
        int          seq_n, cyc, falls, errs, valids, e, eseq, eidx, ebit;
        rx_ent_t     ent;

        rst = 1'b1; word_valid = 1'b0; word_in = '0; ctl_in = '0; serial_in = 1'b0;
        dl = '0; seq_n = 0; cyc = 0; falls = 0; errs = 0; valids = 0;
        resync = 1'b1; prev_lock = 1'b0; lock_chk_done = 1'b0; mid_chk_done = 1'b0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(serial_out == 1'b0, "R11", "serial_out in reset", 32'(serial_out), 0);
        chk(tx_take == 1'b1, "R11", "tx_take in reset", 32'(tx_take), 1);
        chk(rx_lock == 1'b0, "R11", "rx_lock in reset", 32'(rx_lock), 0);
        chk(rx_valid == 1'b0, "R11", "rx_valid in reset", 32'(rx_valid), 0);
        chk(rx_crc_err == 1'b0, "R11", "rx_crc_err in reset", 32'(rx_crc_err), 0);
        chk(rx_word == 16'h0 && rx_ctl == 2'b0, "R11", "rx_word in reset", 32'(rx_word), 0);
        rst = 1'b0;

        forever begin
            @(negedge clk);
            cyc++;

            // Serial line against the reference bit queue.
            flip = 1'b0;
            if (bitq.size() > 0) begin
                e    = bitq.pop_front();
                ebit = e & 1;
                eidx = (e >> 1) & 31;
                eseq = e >> 6;
                chk(serial_out == 1'(ebit), region(eidx, eseq >= 30 && eseq < 35),
                    $sformatf("serial bit %0d of symbol %0d", eidx, eseq),
                    32'(serial_out), 32'(ebit));
                flip = (eseq == 40 && eidx == 20) || (eseq == 50 && eidx == 27) ||
                       ((eseq == 70 || eseq == 71) && eidx == 27);
            end
            dl = {dl[30:0], serial_out ^ flip};
            serial_in = dl[DLY-1];

            // Receive side.
            if (prev_lock && !rx_lock) begin
                falls++;
                resync = 1'b1;
            end
            prev_lock = rx_lock;
            if (rx_crc_err) errs++;
            if (rx_valid) begin
                valids++;
                if (resync) begin
                    while (rxq.size() > 0 &&
                           !(rxq[0].d == rx_word && rxq[0].c == rx_ctl && !rxq[0].drop))
                        void'(rxq.pop_front());
                    resync = 1'b0;
                end
                while (rxq.size() > 0 && rxq[0].drop) void'(rxq.pop_front());
                if (rxq.size() == 0) begin
                    chk(1'b0, "R9", "word with nothing sent", 32'(rx_word), 0);
                end else begin
                    ent = rxq.pop_front();
                    if (!ent.bad) begin
                        chk(rx_word == ent.d, "R9", $sformatf("word of symbol %0d", ent.seq),
                            32'(rx_word), 32'(ent.d));
                        chk(rx_ctl == ent.c, "R9", $sformatf("ctl of symbol %0d", ent.seq),
                            32'(rx_ctl), 32'(ent.c));
                    end
                    chk(rx_crc_err == ent.bad, "R10", $sformatf("crc flag symbol %0d", ent.seq),
                        32'(rx_crc_err), 32'(ent.bad));
                end
            end

            // Transmit drive and expected symbol.
            if (tx_take) begin
                idle = (seq_n >= 30 && seq_n < 35) || seq_n >= NSYM;
                d = $urandom();
                c = 2'($urandom());
                word_valid = !idle;
                word_in    = d;
                ctl_in     = c;
                if (idle) begin d = '0; c = '0; end
                cr  = ref_crc({d, c});
                sym = {1'b1, d ^ key16(), c, cr, ~cr, 1'b0};
                for (int i = 27; i >= 0; i--)
                    bitq.push_back(seq_n * 64 + i * 2 + int'(sym[i]));
                ent.d = d; ent.c = c; ent.seq = seq_n;
                ent.bad  = (seq_n == 40);
                ent.drop = (seq_n == 50);
                rxq.push_back(ent);
                seq_n++;
            end

            if (seq_n == 16 && !lock_chk_done) begin
                lock_chk_done = 1'b1;
                chk(rx_lock == 1'b1, "R7", "lock after clean symbols", 32'(rx_lock), 1);
            end
            if (seq_n == 62 && !mid_chk_done) begin
                mid_chk_done = 1'b1;
                chk(rx_lock == 1'b1 && falls == 0, "R8", "single miss keeps lock",
                    32'(falls), 0);
            end
            if (cyc > LIMIT) begin
                chk(1'b0, "R1", "watchdog expired", 32'(cyc), LIMIT);
                break;
            end
            if (seq_n >= NSYM + 3) break;
        end

        chk(falls == 1, "R8", "lock drops after two misses", 32'(falls), 1);
        chk(rx_lock == 1'b1, "R7", "lock regained", 32'(rx_lock), 1);
        chk(errs == 1, "R10", "crc error pulses", 32'(errs), 1);
        chk(valids >= 100, "R9", "words delivered", 32'(valids), 100);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule